// File: doc/BRIEF.md
# Counted Byte Copy Sequencer

This block moves a run of bytes from one place in memory to another through a single shared memory port. A start pulse loads three values: a 24-bit source pointer, a 24-bit destination pointer and a 16-bit count. It also loads a width bit. The width bit decides whether only the low 8 bits of the count or all 16 bits act as the transfer length. The block moves one byte per iteration: it reads the byte at the source pointer, writes it at the destination pointer, then steps both pointers up by one and the count down by one. It stops when the count reaches zero.

Timing is fixed. Every operation takes 8 + 4n cycles, where n is the starting length. Eight cycles are overhead, split between setup and the final done cycle, and each byte costs two read cycles plus two write cycles. The final pointer and count values stay on the outputs after the operation ends, so the caller can read them and continue from there.

Top module: `block_copier`

## Requirements
- R1: A start pulse is taken only while busy is low. Busy rises on the cycle after the start edge and stays high through the done cycle. Done is high for exactly one cycle, and busy is low on the cycle after it.
- R2: From the accepting edge to the done cycle, inclusive, the operation takes 8 + 4n cycles, where n is the starting length.
- R3: When the width bit is 0, n is count[7:0] and only those 8 bits are tested and decremented. Count[15:8] keeps its loaded value throughout. When the width bit is 1, n is the full 16-bit count.
- R4: If n is zero, mem_req stays low for the whole operation and done arrives 8 cycles after the start edge.
- R5: Each byte uses two read cycles (mem_req=1, mem_we=0, mem_addr=source) and then two write cycles (mem_req=1, mem_we=1, mem_addr=destination). Read data is taken in the second read cycle, and that byte is driven on mem_wdata during the writes.
- R6: After each byte, both pointers increase by 1 modulo 2^24 and the selected count decreases by 1.
- R7: During the done cycle, and after it, src_q and dst_q equal the start values plus n modulo 2^24, and the selected count bits read zero.
- R8: A start pulse while busy is ignored. The running operation's results and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start request, taken when idle |
| wide | input | 1 | 1 = 16-bit length, 0 = 8-bit length |
| src_in | input | 24 | Start source pointer |
| dst_in | input | 24 | Start destination pointer |
| cnt_in | input | 16 | Start count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| src_q | output | 24 | Current source pointer |
| dst_q | output | 24 | Current destination pointer |
| cnt_q | output | 16 | Current count |
| mem_req | output | 1 | Memory access cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in second read cycle |

## Verification
Two events can fall in the same cycle: the last write cycle of a byte, where the pointers step and the count is decremented, and the test that decides between finishing and starting another byte. Runs of length 1, a 258-byte run in 16-bit mode, and 8-bit runs with nonzero upper count bits all drive the decrement to zero on that edge. In each case the bench judges the exact done cycle and counts the memory cycles against 8 + 4n. A second collision comes from a new start pulse that arrives while busy is high; it must leave the final pointers, count and timing unchanged.

// File: rtl/block_copier.sv
module block_copier #(
  parameter int AW = 24,
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int SETUP_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wide,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int SW = $clog2(SETUP_CYC);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RD1, S_RD2, S_WR1, S_WR2, S_FIN} st_t;

  st_t           st;
  logic [SW-1:0] tmr;
  logic          wide_q;
  logic [DW-1:0] hold;

  wire [CW-1:0] cnt_dec  = wide_q ? cnt_q - 1'b1 : {cnt_q[CW-1:8], cnt_q[7:0] - 8'd1};
  wire          sel_zero = wide_q ? (cnt_q == '0) : (cnt_q[7:0] == 8'd0);
  wire          dec_zero = wide_q ? (cnt_q == CW'(1)) : (cnt_q[7:0] == 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      wide_q <= 1'b0;
      hold   <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          src_q  <= src_in;
          dst_q  <= dst_in;
          cnt_q  <= cnt_in;
          wide_q <= wide;
          tmr    <= '0;
          st     <= S_SETUP;
        end
        S_SETUP: begin
          if (tmr == SW'(SETUP_CYC - 2)) st <= sel_zero ? S_FIN : S_RD1;
          else tmr <= tmr + 1'b1;
        end
        S_RD1: st <= S_RD2;
        S_RD2: begin
          hold <= mem_rdata;
          st   <= S_WR1;
        end
        S_WR1: st <= S_WR2;
        S_WR2: begin
          src_q <= src_q + 1'b1;
          dst_q <= dst_q + 1'b1;
          cnt_q <= cnt_dec;
          st    <= dec_zero ? S_FIN : S_RD1;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign mem_req   = (st == S_RD1) || (st == S_RD2) || (st == S_WR1) || (st == S_WR2);
  assign mem_we    = (st == S_WR1) || (st == S_WR2);
  assign mem_addr  = mem_we ? dst_q : src_q;
  assign mem_wdata = hold;

  // R1
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R7
  done_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wide_q ? (cnt_q == '0) : (cnt_q[7:0] == 8'd0)));
  // R3
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wide_q) |=> $stable(cnt_q[CW-1:8]));
  // R5
  wdata_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR1) |-> (mem_wdata == $past(mem_rdata)));
  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_WR2) |-> (src_q == $past(src_q) + 1'b1 && dst_q == $past(dst_q) + 1'b1));
  // R4
  zero_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETUP && sel_zero) |-> !mem_req);
endmodule

// File: tb/sim_block_copier.sv
module sim_block_copier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wide = 1'b0;
  logic [23:0] src_in = '0, dst_in = '0;
  logic [15:0] cnt_in = '0;
  logic busy, done, mem_req, mem_we;
  logic [23:0] src_q, dst_q, mem_addr;
  logic [15:0] cnt_q;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [1024];
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  block_copier u0 (.clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
    .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .busy(busy), .done(done),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    else if (mem_req) mem_rdata <= mem[mem_addr[9:0]];
  end

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
  endtask

  task automatic run(bit w, logic [23:0] s, logic [23:0] d, logic [15:0] c, bit poke);
    int n, cyc, rd, wr, nobusy;
    logic [15:0] cexp;
    fill();
    n = w ? int'(c) : int'(c[7:0]);
    @(negedge clk);
    start = 1; wide = w; src_in = s; dst_in = d; cnt_in = c;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    cyc = 0; rd = 0; wr = 0; nobusy = 0;
    forever begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      if (!busy) nobusy++;
      if (mem_req && mem_we) wr++;
      else if (mem_req) rd++;
      if (poke && cyc == 3) begin
        start = 1; wide = ~w; src_in = 24'h123; dst_in = 24'h321; cnt_in = 16'h0007;
      end else start = 0;
      if (done || cyc > 70000) break;
    end
    chk(nobusy == 0, "R1", "busy low before done", nobusy, 0);
    chk(cyc == 8 + 4 * n, poke ? "R8" : "R2", "cycles to done", cyc, 8 + 4 * n);
    chk(rd == 2 * n && wr == 2 * n, n == 0 ? "R4" : "R5", "read/write cycles", rd * 65536 + wr, 2 * n * 65536 + 2 * n);
    chk(src_q == s + 24'(n), "R7", "src_q", src_q, s + 24'(n));
    chk(dst_q == d + 24'(n), "R6", "dst_q", dst_q, d + 24'(n));
    cexp = w ? 16'h0 : {c[15:8], 8'h00};
    chk(cnt_q == cexp, "R3", "cnt_q", cnt_q, cexp);
    for (int i = 0; i < n; i++)
      if (mem[(int'(d[9:0]) + i) % 1024] != pat((int'(s[9:0]) + i) % 1024)) begin
        chk(0, "R5", "dst byte", mem[(int'(d[9:0]) + i) % 1024], pat((int'(s[9:0]) + i) % 1024));
        break;
      end
    chk(mem[(int'(d[9:0]) + n) % 1024] == pat((int'(d[9:0]) + n) % 1024), "R6",
        "byte past end", mem[(int'(d[9:0]) + n) % 1024], pat((int'(d[9:0]) + n) % 1024));
    @(negedge clk);
    chk(!busy && !done, "R1", "idle after done", {busy, done}, 0);
    chk(src_q == s + 24'(n) && cnt_q == cexp, "R7", "results held", src_q, s + 24'(n));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1", "reset outputs", {busy, done, mem_req}, 0);
    chk(src_q == 0 && dst_q == 0 && cnt_q == 0, "R7", "reset regs", src_q, 0);
    rst_n = 1;
  endtask

  task automatic t_byte_short();   run(0, 24'h000010, 24'h000200, 16'h0003, 0); endtask
  task automatic t_byte_upper();   run(0, 24'h000040, 24'h000300, 16'hAB05, 0); endtask
  task automatic t_zero_byte();    run(0, 24'h000020, 24'h000100, 16'h0500, 0); endtask
  task automatic t_zero_word();    run(1, 24'h000020, 24'h000100, 16'h0000, 0); endtask
  task automatic t_one();          run(1, 24'h000001, 24'h000101, 16'h0001, 0); endtask
  task automatic t_word_long();    run(1, 24'h000000, 24'h000200, 16'h0102, 0); endtask
  task automatic t_wrap();         run(0, 24'hFFFFFE, 24'h0001F0, 16'h0004, 0); endtask
  task automatic t_busy_start();   run(0, 24'h000050, 24'h000250, 16'h0006, 1); endtask

  initial begin
    fork
      begin
        t_reset();
        t_byte_short();
        t_byte_upper();
        t_zero_byte();
        t_zero_word();
        t_one();
        t_word_long();
        t_wrap();
        t_busy_start();
      end
      begin
        repeat (150000) @(posedge clk);
        chk(0, "R2", "watchdog expired", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule